// File: doc/BRIEF.md
# Peripheral-paced DMA channel

This block is one channel of a direct memory access engine that feeds a peripheral's data register from memory, one byte per peripheral request. Software programs a memory source address, a fixed peripheral destination address, a transfer count, a priority value and two interrupt enables through a small register port, then sets the activate bit. Each time the peripheral raises its request while the channel is active and has transfers left, the channel reads one byte from memory, writes it to the destination and acknowledges the request in the same cycle as the write.

The channel keeps a running count of the transfers still owed. It raises a sticky half-way flag when the remaining count first equals the programmed count halved (rounded down), and a sticky completion flag when it reaches zero. On completion it clears its own activate bit, so later requests are ignored until software turns it on again. Flags are cleared by writing ones to a clear register, and an interrupt line is the OR of the flags whose enables are set. The priority field is only stored and read back.

Top module: `pdma_channel`

## Requirements
- R1: After reset every readable register reads zero, `irq` is low and no memory read, peripheral write or acknowledge is active.
- R2: Register offsets on `cfg_addr`: 0 control (bit 0 activate, bit 1 half-way interrupt enable, bit 2 completion interrupt enable, priority from bit 4), 1 source address (reads the current pointer), 2 destination address, 3 count (a write sets total and remaining; a read gives remaining), 4 flags (bit 0 half-way, bit 1 completion), 5 flag clear (write only, reads zero). Written values read back.
- R3: While the activate bit is 0, a held request causes no memory read, no peripheral write and no acknowledge; re-activating resumes from the remaining count.
- R4: A request seen in an idle cycle with the channel active and remaining count nonzero gives a memory read at the source pointer one cycle later and, the cycle after that, a peripheral write of the returned byte with `per_ack` high.
- R5: The source pointer steps up by one after each transfer; the peripheral address is always the destination register value.
- R6: The remaining count drops by one per transfer.
- R7: The half-way flag is set by the transfer that brings the remaining count to the programmed count shifted right by one.
- R8: The transfer that brings the remaining count to zero sets the completion flag and clears the activate bit; further requests are then ignored.
- R9: `irq` is high exactly when (half-way flag and its enable) or (completion flag and its enable).
- R10: Writing a 1 to bit 0 or bit 1 of the clear register clears the matching flag; other flags stay.
- R11: With a programmed count of zero and the channel active, requests move nothing and neither flag is set.
- R12: The priority field is stored as written and reads back unchanged; it does not affect transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the strobe |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Acknowledge, high in the write cycle |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_addr | output | ADDR_W | Peripheral register address |
| per_wdata | output | DATA_W | Peripheral write data |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong source pointer shows at `mem_addr` and in `per_wdata` on the very next transfer, and a miscounted remaining value moves the half-way or completion flag to a different transfer, visible in the flag register and on `irq` one cycle after that transfer's write. A stale activate bit shows up as an acknowledge to a request after completion or while disabled, within three cycles of the request. The bench sweeps every count from 0 to 6 against all four interrupt-enable combinations, checking every transfer's address, data and timing, and the count, flags and interrupt after each one.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_FLAG = 3'd4;
  localparam logic [2:0] REG_FCLR = 3'd5;

  localparam int CTL_EN   = 0;
  localparam int CTL_HIE  = 1;
  localparam int CTL_CIE  = 2;
  localparam int CTL_PRIO = 4;

  localparam int NFLAG    = 2;
  localparam int FLG_HALF = 0;
  localparam int FLG_DONE = 1;
endpackage

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              per_req,
  input  logic              src_load,
  input  logic [ADDR_W-1:0] src_load_val,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_load_val,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              per_wr_en,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              per_ack,
  output logic [ADDR_W-1:0] src_cur,
  output logic [CNT_W-1:0]  remaining,
  output logic              half_hit,
  output logic              done_hit
);
  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [CNT_W-1:0]  rem_q, rem_d, total_q, rem_dec;
  logic              fire, src_en, rem_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (enable && per_req && (rem_q != '0)) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign fire    = (state_q == ST_WRITE);
  assign rem_dec = rem_q - 1'b1;

  always_comb begin
    src_en = src_load | fire;
    src_d  = src_load ? src_load_val : src_q + 1'b1;
    rem_en = cnt_load | fire;
    rem_d  = cnt_load ? cnt_load_val : rem_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      rem_q   <= '0;
      total_q <= '0;
    end else begin
      state_q <= state_d;
      if (src_en)   src_q   <= src_d;
      if (rem_en)   rem_q   <= rem_d;
      if (cnt_load) total_q <= cnt_load_val;
    end
  end

  assign mem_rd_en = (state_q == ST_READ);
  assign mem_addr  = src_q;
  assign per_wr_en = fire;
  assign per_ack   = fire;
  assign per_addr  = dst_addr;
  assign per_wdata = mem_rdata;
  assign src_cur   = src_q;
  assign remaining = rem_q;
  assign half_hit  = fire && (rem_dec == (total_q >> 1));
  assign done_hit  = fire && (rem_dec == '0);

  // R4: every peripheral write follows a memory read in the previous cycle
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |-> $past(mem_rd_en));

  // R5: the source pointer advances by exactly one per transfer
  p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr_en && !src_load) |=> (src_cur == $past(src_cur) + 1'b1));

  // R6: the remaining count drops by exactly one per transfer
  p_rem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr_en && !cnt_load) |=> (remaining == $past(remaining) - 1'b1));

  // R11: no memory read is issued with nothing left to move
  p_no_read_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (remaining != '0));
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] src_cur,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              half_hit,
  input  logic              done_hit,
  output logic              enable,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              src_load,
  output logic [ADDR_W-1:0] src_load_val,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              irq
);
  logic              en_q, en_d, hie_q, cie_q;
  logic [PRIO_W-1:0] prio_q;
  logic [ADDR_W-1:0] dst_q;
  logic [NFLAG-1:0]  flag_q, flag_d, set_vec, clr_vec, ie_vec;
  logic              ctrl_wr, dst_wr;
  logic              unused_wdata;

  assign ctrl_wr      = cfg_we && (cfg_addr == REG_CTRL);
  assign dst_wr       = cfg_we && (cfg_addr == REG_DST);
  assign src_load     = cfg_we && (cfg_addr == REG_SRC);
  assign cnt_load     = cfg_we && (cfg_addr == REG_CNT);
  assign src_load_val = cfg_wdata[ADDR_W-1:0];
  assign cnt_load_val = cfg_wdata[CNT_W-1:0];
  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    en_d = en_q;
    if (done_hit)     en_d = 1'b0;
    else if (ctrl_wr) en_d = cfg_wdata[CTL_EN];
  end

  assign set_vec[FLG_HALF] = half_hit;
  assign set_vec[FLG_DONE] = done_hit;
  assign clr_vec = (cfg_we && (cfg_addr == REG_FCLR)) ? cfg_wdata[NFLAG-1:0] : '0;
  assign ie_vec[FLG_HALF] = hie_q;
  assign ie_vec[FLG_DONE] = cie_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_d[i] = set_vec[i] | (flag_q[i] & ~clr_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hie_q  <= 1'b0;
      cie_q  <= 1'b0;
      prio_q <= '0;
      dst_q  <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      if (ctrl_wr) begin
        hie_q  <= cfg_wdata[CTL_HIE];
        cie_q  <= cfg_wdata[CTL_CIE];
        prio_q <= cfg_wdata[CTL_PRIO +: PRIO_W];
      end
      if (dst_wr) dst_q <= cfg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL: begin
        cfg_rdata[CTL_EN]              = en_q;
        cfg_rdata[CTL_HIE]             = hie_q;
        cfg_rdata[CTL_CIE]             = cie_q;
        cfg_rdata[CTL_PRIO +: PRIO_W]  = prio_q;
      end
      REG_SRC:  cfg_rdata = 32'(src_cur);
      REG_DST:  cfg_rdata = 32'(dst_q);
      REG_CNT:  cfg_rdata = 32'(remaining);
      REG_FLAG: cfg_rdata[NFLAG-1:0] = flag_q;
      default:  cfg_rdata = '0;
    endcase
  end

  assign enable   = en_q;
  assign dst_addr = dst_q;
  assign irq      = |(flag_q & ie_vec);

  // R8: completion always switches the channel off
  p_done_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> !enable);

  // R10: the half-way flag only falls through a clear write
  p_half_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[FLG_HALF]) |-> $past(cfg_we && (cfg_addr == REG_FCLR) && cfg_wdata[FLG_HALF]));

  // R10: the completion flag only falls through a clear write
  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[FLG_DONE]) |-> $past(cfg_we && (cfg_addr == REG_FCLR) && cfg_wdata[FLG_DONE]));
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic              per_wr_en,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              enable, src_load, cnt_load, half_hit, done_hit;
  logic [ADDR_W-1:0] dst_addr, src_cur, src_load_val;
  logic [CNT_W-1:0]  remaining, cnt_load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_cur(src_cur), .remaining(remaining), .half_hit(half_hit), .done_hit(done_hit),
    .enable(enable), .dst_addr(dst_addr),
    .src_load(src_load), .src_load_val(src_load_val),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .irq(irq)
  );

  pdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_int_n),
    .enable(enable), .per_req(per_req),
    .src_load(src_load), .src_load_val(src_load_val),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .dst_addr(dst_addr), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .per_wr_en(per_wr_en), .per_addr(per_addr), .per_wdata(per_wdata), .per_ack(per_ack),
    .src_cur(src_cur), .remaining(remaining),
    .half_hit(half_hit), .done_hit(done_hit)
  );
endmodule

// File: tb/tb_pdma_channel.sv
module tb_pdma_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        per_req, per_ack, per_wr_en;
  logic [15:0] per_addr;
  logic [7:0]  per_wdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pdma_channel dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_wr_en(per_wr_en),
    .per_addr(per_addr), .per_wdata(per_wdata), .irq(irq)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8];
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_val(mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic run_xfer(input logic [15:0] src, input logic [15:0] dst);
    @(negedge clk);
    per_req = 1'b1;
    @(negedge clk);
    chk(mem_rd_en && !per_ack, "R4 read cycle", {31'd0, mem_rd_en}, 32'd1);
    chk(mem_addr == src, "R5 read address", 32'(mem_addr), 32'(src));
    @(negedge clk);
    chk(per_ack && per_wr_en, "R4 ack with write", {30'd0, per_ack, per_wr_en}, 32'd3);
    chk(per_wdata == mem_val(src), "R4 write data", 32'(per_wdata), 32'(mem_val(src)));
    chk(per_addr == dst, "R5 destination fixed", 32'(per_addr), 32'(dst));
    per_req = 1'b0;
  endtask

  task automatic no_xfer(input int n, input string tag);
    int seen = 0;
    @(negedge clk);
    per_req = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (per_ack || per_wr_en || mem_rd_en) seen++;
    end
    per_req = 1'b0;
    chk(seen == 0, tag, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; per_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register reset", d, 0);
    end
    chk(!irq && !per_ack && !mem_rd_en && !per_wr_en, "R1 outputs idle",
        {28'd0, irq, per_ack, mem_rd_en, per_wr_en}, 0);

    // R3: disabled channel ignores requests, resumes on re-activate
    wr(3'd1, 32'h0200); wr(3'd2, 32'h5A5A); wr(3'd3, 32'd4);
    no_xfer(6, "R3 no transfer while inactive");
    rd(3'd2, d); chk(d == 32'h5A5A, "R2 destination readback", d, 32'h5A5A);
    wr(3'd0, 32'h1);
    run_xfer(16'h0200, 16'h5A5A);
    run_xfer(16'h0201, 16'h5A5A);
    wr(3'd0, 32'h0);
    no_xfer(6, "R3 no transfer after deactivate");
    rd(3'd3, d); chk(d == 2, "R3 remaining kept", d, 2);
    wr(3'd0, 32'h1);
    run_xfer(16'h0202, 16'h5A5A);
    run_xfer(16'h0203, 16'h5A5A);
    rd(3'd4, d); chk(d == 3, "R8 flags after resumed run", d, 3);
    wr(3'd5, 32'h3);

    // Sweep of counts against interrupt-enable combinations
    for (int total = 0; total < 7; total++) begin
      for (int ie = 0; ie < 4; ie++) begin
        logic [15:0] base, dst;
        logic [31:0] ctrl;
        bit hie, cie, hexp, cexp;
        base = 16'h0100 + 16'(total * 16'h37) + 16'(ie * 3);
        dst  = 16'h4000 + 16'(total * 4 + ie);
        hie  = ie[0]; cie = ie[1];
        ctrl = 32'h1 | (32'(ie) << 1) | (32'(ie) << 4);
        wr(3'd1, 32'(base)); wr(3'd2, 32'(dst)); wr(3'd3, 32'(total));
        wr(3'd5, 32'h3);
        wr(3'd0, ctrl);
        rd(3'd0, d);
        chk(d == ctrl, "R12 control and priority readback", d, ctrl);
        for (int k = 1; k <= total; k++) begin
          run_xfer(base + 16'(k - 1), dst);
          rd(3'd3, d);
          chk(d == 32'(total - k), "R6 remaining count", d, 32'(total - k));
          hexp = (total - k) <= (total / 2);
          cexp = (k == total);
          rd(3'd4, d);
          chk(d[0] == hexp, "R7 half-way flag", d, {30'd0, cexp, hexp});
          chk(d[1] == cexp, "R8 completion flag", d, {30'd0, cexp, hexp});
          chk(irq == ((hexp && hie) || (cexp && cie)), "R9 interrupt",
              32'(irq), 32'((hexp && hie) || (cexp && cie)));
        end
        if (total == 0) begin
          no_xfer(6, "R11 zero count moves nothing");
          rd(3'd4, d); chk(d == 0, "R11 zero count no flags", d, 0);
          chk(!irq, "R11 zero count no interrupt", 32'(irq), 0);
        end else begin
          rd(3'd0, d); chk(d[0] == 1'b0, "R8 activate cleared", d, ctrl & ~32'h1);
          no_xfer(6, "R8 requests ignored after completion");
          rd(3'd1, d);
          chk(d == 32'(base + 16'(total)), "R5 pointer after run", d, 32'(base + 16'(total)));
          wr(3'd5, 32'h1);
          rd(3'd4, d); chk(d == 32'h2, "R10 clear half only", d, 32'h2);
          chk(irq == cie, "R9 interrupt after half clear", 32'(irq), 32'(cie));
          wr(3'd5, 32'h2);
          rd(3'd4, d); chk(d == 0, "R10 clear completion", d, 0);
          chk(!irq, "R10 interrupt low after clears", 32'(irq), 0);
        end
        rd(3'd5, d); chk(d == 0, "R2 clear register reads zero", d, 0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule